// File: doc/BRIEF.md
# Serial-Loaded Bank Register File

This block sits on a processor write bus and fills four 5-bit configuration registers one bit at a time. Each write to the upper half of the address space delivers a single bit, taken from data bit 0. Five such writes build a word in a small shift register, least significant bit first. The fifth write commits that word to the register that its address selects. The shift register carries a marker bit, so it needs no separate bit counter. When the marker reaches the bottom position, the next write completes the word.

A write with the top data bit set drops any partial word and forces the two mode bits of the control register high. A guard counter discards writes that come too soon after an accepted one. A hard reset and a soft reset both restore the control and bank registers. Only the hard reset clears the character bank registers and the guard. Every register update produces a one-cycle pulse that carries the index of the register that changed.

Top module: `serial_bank_loader`

## Requirements
- R1: A write is considered only when `wr_en` is high and `addr[15]` is 1. Writes below address 0x8000 change no register and no shift state.
- R2: Five accepted writes assemble a word least significant bit first: the first write supplies bit 0 and the fifth supplies bit 4. Only data bit 0 is used, and data bits 6..1 have no effect.
- R3: The fifth write commits the word to the register that `addr[14:13]` selects: 0 control, 1 character bank 0, 2 character bank 1, 3 program bank. The other three registers keep their values, and `addr[12:0]` has no effect.
- R4: After a commit the shift state is empty, so the next five accepted writes build a new word.
- R5: After an accepted write, writes presented in the next two clock cycles are ignored. A write in the third cycle after it is accepted.
- R6: An accepted write with data bit 7 set shifts no bit and discards any partial word. It sets control bits 3:2 to 11 and keeps control bits 4, 1 and 0. It also starts the guard window of R5.
- R7: A commit or a bit-7 write raises `commit_pulse` for exactly one cycle, with `commit_sel` set to the index of the updated register (0 for a bit-7 write). The new register value appears in the same cycle as the pulse.
- R8: A soft reset sets control to 0x0C and the program bank to 0x10, and discards a partial word. It keeps both character banks and does not clear the guard window.
- R9: A hard reset sets control to 0x0C, the program bank to 0x10 and both character banks to 0. It also clears the guard window, so a write in the cycle after the reset is accepted.
- R10: Writes one to four of a word produce no `commit_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous active-high full reset |
| soft_rst | input | 1 | Synchronous active-high reset that keeps the character banks and the guard |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 16 | Write address |
| data | input | 8 | Write data: bit 0 is the serial bit, bit 7 is the abort and force-mode bit |
| ctrl_q | output | 5 | Control register |
| chr0_q | output | 5 | Character bank 0 register |
| chr1_q | output | 5 | Character bank 1 register |
| prg_q | output | 5 | Program bank register |
| commit_pulse | output | 1 | One-cycle pulse on any register update |
| commit_sel | output | 2 | Index of the updated register |

## Verification
Words are loaded into all four registers using asymmetric bit patterns, with noise in the unused data bits and in the low address bits. A wrong bit order, a mixed-in bit or a misdecoded target therefore gives a visibly different value. Stray writes below 0x8000, and writes spaced one, two and three cycles apart, show whether the address gate and the guard window drop exactly the right writes: an extra accepted bit shifts the whole word. A bit-7 write that arrives partway through a word must leave a fresh five-write load intact, which separates discarding the partial word from keeping it. Each reset type is applied with the guard window open and a write just after it, which shows whether that reset clears the guard.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
    localparam int REG_W        = 5;
    localparam int ADDR_W       = 16;
    localparam int DATA_W       = 8;
    localparam int GUARD_CYCLES = 2;

    typedef logic [REG_W-1:0] cfg_t;

    localparam cfg_t SHIFT_IDLE    = cfg_t'(1) << (REG_W - 1);
    localparam cfg_t MODE_BITS     = 5'b01100;
    localparam cfg_t CTRL_DEFAULT  = 5'b01100;
    localparam cfg_t PRG_DEFAULT   = 5'b10000;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CHR0 = 2'd1,
        SEL_CHR1 = 2'd2,
        SEL_PRG  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     load;
        logic     force_mode;
        reg_sel_e sel;
        cfg_t     value;
    } commit_t;

    function automatic cfg_t hard_default(input reg_sel_e s);
        case (s)
            SEL_CTRL: return CTRL_DEFAULT;
            SEL_PRG:  return PRG_DEFAULT;
            default:  return '0;
        endcase
    endfunction

    function automatic logic soft_resets(input reg_sel_e s);
        return (s == SEL_CTRL) || (s == SEL_PRG);
    endfunction
endpackage

// File: rtl/sbl_guard.sv
module sbl_guard #(
    parameter int GUARD_CYCLES = sbl_pkg::GUARD_CYCLES
) (
    input  logic clk,
    input  logic hard_rst,
    input  logic arm,
    output logic busy
);
    localparam int CW = $clog2(GUARD_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (hard_rst)
            cnt_q <= '0;
        else if (arm)
            cnt_q <= CW'(GUARD_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/sbl_shifter.sv
module sbl_shifter
    import sbl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    input  logic abort,
    input  logic bit_in,
    output logic last_bit,
    output cfg_t word
);
    cfg_t sr_q;

    always_ff @(posedge clk) begin
        if (rst || abort)
            sr_q <= SHIFT_IDLE;
        else if (shift_en)
            sr_q <= sr_q[0] ? SHIFT_IDLE : {bit_in, sr_q[REG_W-1:1]};
    end

    assign last_bit = sr_q[0];
    assign word     = {bit_in, sr_q[REG_W-1:1]};
endmodule

// File: rtl/sbl_regfile.sv
module sbl_regfile
    import sbl_pkg::*;
(
    input  logic     clk,
    input  logic     hard_rst,
    input  logic     soft_rst,
    input  commit_t  cmd,
    output cfg_t     ctrl_q,
    output cfg_t     chr0_q,
    output cfg_t     chr1_q,
    output cfg_t     prg_q,
    output logic     pulse_q,
    output reg_sel_e sel_q
);
    localparam int NREG = 4;

    cfg_t regs_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam reg_sel_e IDX = reg_sel_e'(i);
        always_ff @(posedge clk) begin
            if (hard_rst)
                regs_q[i] <= hard_default(IDX);
            else if (soft_rst) begin
                if (soft_resets(IDX))
                    regs_q[i] <= hard_default(IDX);
            end else if (cmd.force_mode && IDX == SEL_CTRL)
                regs_q[i] <= regs_q[i] | MODE_BITS;
            else if (cmd.load && cmd.sel == IDX)
                regs_q[i] <= cmd.value;
        end
    end

    always_ff @(posedge clk) begin
        if (hard_rst || soft_rst) begin
            pulse_q <= 1'b0;
            sel_q   <= SEL_CTRL;
        end else begin
            pulse_q <= cmd.load || cmd.force_mode;
            sel_q   <= cmd.force_mode ? SEL_CTRL : cmd.sel;
        end
    end

    assign ctrl_q = regs_q[SEL_CTRL];
    assign chr0_q = regs_q[SEL_CHR0];
    assign chr1_q = regs_q[SEL_CHR1];
    assign prg_q  = regs_q[SEL_PRG];
endmodule

// File: rtl/serial_bank_loader.sv
module serial_bank_loader
    import sbl_pkg::*;
#(
    parameter int ADDR_W       = sbl_pkg::ADDR_W,
    parameter int DATA_W       = sbl_pkg::DATA_W,
    parameter int GUARD_CYCLES = sbl_pkg::GUARD_CYCLES
) (
    input  logic              clk,
    input  logic              hard_rst,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [4:0]        ctrl_q,
    output logic [4:0]        chr0_q,
    output logic [4:0]        chr1_q,
    output logic [4:0]        prg_q,
    output logic              commit_pulse,
    output logic [1:0]        commit_sel
);
    logic     busy;
    logic     wr_ok;
    logic     do_shift;
    logic     do_abort;
    logic     last_bit;
    cfg_t     word;
    commit_t  cmd;
    reg_sel_e sel_q;
    logic     unused_bits;

    assign wr_ok    = wr_en && addr[ADDR_W-1] && !busy && !hard_rst && !soft_rst;
    assign do_abort = wr_ok && data[DATA_W-1];
    assign do_shift = wr_ok && !data[DATA_W-1];

    sbl_guard #(.GUARD_CYCLES(GUARD_CYCLES)) u_guard (
        .clk      (clk),
        .hard_rst (hard_rst),
        .arm      (wr_ok),
        .busy     (busy)
    );

    sbl_shifter u_shift (
        .clk      (clk),
        .rst      (hard_rst || soft_rst),
        .shift_en (do_shift),
        .abort    (do_abort),
        .bit_in   (data[0]),
        .last_bit (last_bit),
        .word     (word)
    );

    always_comb begin
        cmd.load       = do_shift && last_bit;
        cmd.force_mode = do_abort;
        cmd.sel        = reg_sel_e'(addr[ADDR_W-2 -: 2]);
        cmd.value      = word;
    end

    sbl_regfile u_regs (
        .clk      (clk),
        .hard_rst (hard_rst),
        .soft_rst (soft_rst),
        .cmd      (cmd),
        .ctrl_q   (ctrl_q),
        .chr0_q   (chr0_q),
        .chr1_q   (chr1_q),
        .prg_q    (prg_q),
        .pulse_q  (commit_pulse),
        .sel_q    (sel_q)
    );

    assign commit_sel  = sel_q;
    assign unused_bits = ^{addr[ADDR_W-4:0], data[DATA_W-2:1]};
endmodule

// File: rtl/sbl_checker.sv
module sbl_checker (
    input logic       clk,
    input logic       hard_rst,
    input logic       soft_rst,
    input logic       wr_ok,
    input logic       wr_msb,
    input logic [4:0] ctrl_q,
    input logic [4:0] chr0_q,
    input logic [4:0] chr1_q,
    input logic [4:0] prg_q,
    input logic       commit_pulse,
    input logic [1:0] commit_sel
);
    p_hard_defaults_r9: assert property (@(posedge clk)
        hard_rst |=> ctrl_q == 5'h0C && prg_q == 5'h10 && chr0_q == 5'h00
                     && chr1_q == 5'h00 && !commit_pulse);

    p_soft_defaults_r8: assert property (@(posedge clk) disable iff (hard_rst)
        soft_rst |=> ctrl_q == 5'h0C && prg_q == 5'h10 && !commit_pulse);

    p_soft_keeps_chr_r8: assert property (@(posedge clk) disable iff (hard_rst)
        soft_rst |=> $stable(chr0_q) && $stable(chr1_q));

    p_pulse_gap_r5: assert property (@(posedge clk) disable iff (hard_rst)
        commit_pulse |=> !commit_pulse);

    p_force_mode_r6: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
        wr_ok && wr_msb |=> commit_pulse && commit_sel == 2'd0 && ctrl_q[3:2] == 2'b11);

    p_pulse_cause_r7: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
        commit_pulse |-> $past(wr_ok));

    p_only_target_ctrl_r3: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
        commit_pulse && commit_sel == 2'd0 |-> $stable(chr0_q) && $stable(chr1_q) && $stable(prg_q));

    p_only_target_chr0_r3: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
        commit_pulse && commit_sel == 2'd1 |-> $stable(ctrl_q) && $stable(chr1_q) && $stable(prg_q));
endmodule

bind serial_bank_loader sbl_checker u_chk (
    .clk          (clk),
    .hard_rst     (hard_rst),
    .soft_rst     (soft_rst),
    .wr_ok        (wr_ok),
    .wr_msb       (data[7]),
    .ctrl_q       (ctrl_q),
    .chr0_q       (chr0_q),
    .chr1_q       (chr1_q),
    .prg_q        (prg_q),
    .commit_pulse (commit_pulse),
    .commit_sel   (commit_sel)
);

// File: tb/sim_serial_bank_loader.sv
module sim_serial_bank_loader;
    logic        clk = 1'b0;
    logic        hard_rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  data = '0;
    logic [4:0]  ctrl_q, chr0_q, chr1_q, prg_q;
    logic        commit_pulse;
    logic [1:0]  commit_sel;

    int n_checks = 0;
    int n_fail   = 0;
    logic [4:0] e_ctrl, e_chr0, e_chr1, e_prg;

    always #10 clk = ~clk;

    serial_bank_loader u0 (
        .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .wr_en(wr_en),
        .addr(addr), .data(data), .ctrl_q(ctrl_q), .chr0_q(chr0_q),
        .chr1_q(chr1_q), .prg_q(prg_q), .commit_pulse(commit_pulse),
        .commit_sel(commit_sel)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        check(req, "ctrl", 32'(ctrl_q), 32'(e_ctrl));
        check(req, "chr0", 32'(chr0_q), 32'(e_chr0));
        check(req, "chr1", 32'(chr1_q), 32'(e_chr1));
        check(req, "prg",  32'(prg_q),  32'(e_prg));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one write held across one rising edge; returns just after that edge
    task automatic drive_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; data = d;
        @(negedge clk);
        wr_en = 1'b0; data = '0;
    endtask

    task automatic set_exp(input logic [15:0] a, input logic [4:0] v);
        case (a[14:13])
            2'd0: e_ctrl = v;
            2'd1: e_chr0 = v;
            2'd2: e_chr1 = v;
            default: e_prg = v;
        endcase
    endtask

    // five writes at the minimum spacing, noise in data bits 6..1 (R2, R4, R10, R7)
    task automatic load_reg(input string req, input logic [15:0] a, input logic [4:0] v);
        for (int i = 0; i < 5; i++) begin
            drive_write(a, {1'b0, 6'b101101 ^ 6'(i * 9), v[i]});
            if (i < 4) begin
                check("R10", "no pulse mid-word", 32'(commit_pulse), 32'd0);
            end else begin
                set_exp(a, v);
                check(req, "pulse", 32'(commit_pulse), 32'd1);
                check("R7", "sel", 32'(commit_sel), 32'(a[14:13]));
                check_regs(req);
            end
            idle(1);
        end
        check("R7", "pulse one cycle", 32'(commit_pulse), 32'd0);
    endtask

    task automatic t_reset;
        hard_rst = 1'b1;
        idle(3);
        hard_rst = 1'b0;
        e_ctrl = 5'h0C; e_chr0 = 5'h00; e_chr1 = 5'h00; e_prg = 5'h10;
        check_regs("R9");
        check("R9", "pulse idle", 32'(commit_pulse), 32'd0);
    endtask

    task automatic t_load_all;
        load_reg("R3", 16'h9FFF, 5'h13);
        load_reg("R3", 16'hA123, 5'h0A);
        load_reg("R3", 16'hC7FF, 5'h15);
        load_reg("R2", 16'hE000, 5'h07);
    endtask

    task automatic t_low_addr;
        for (int i = 0; i < 3; i++) begin
            drive_write(16'h7FFF, 8'h01);
            idle(1);
            drive_write(16'h0000, 8'h01);
            idle(1);
        end
        check("R1", "no pulse low addr", 32'(commit_pulse), 32'd0);
        check_regs("R1");
        load_reg("R1", 16'hB000, 5'h1E);
    endtask

    task automatic t_guard;
        @(negedge clk);
        wr_en = 1'b1; addr = 16'hC000; data = 8'h01;
        @(negedge clk);
        data = 8'h00;
        @(negedge clk);
        data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        // bits 1,0,1,1 follow the accepted 1 -> 5'b11011
        drive_write(16'hC000, 8'h01); idle(1);
        drive_write(16'hC000, 8'h00); idle(1);
        drive_write(16'hC000, 8'h01); idle(1);
        check("R5", "no early commit", 32'(commit_pulse), 32'd0);
        drive_write(16'hC000, 8'h01);
        e_chr1 = 5'h1B;
        check("R5", "pulse", 32'(commit_pulse), 32'd1);
        check_regs("R5");
        idle(1);
    endtask

    task automatic t_bit7;
        load_reg("R3", 16'h8000, 5'h11);
        drive_write(16'hA000, 8'h01); idle(1);
        drive_write(16'hA000, 8'h01); idle(1);
        drive_write(16'h8000, 8'h81);
        e_ctrl = 5'h1D;
        check("R6", "pulse", 32'(commit_pulse), 32'd1);
        check("R6", "sel", 32'(commit_sel), 32'd0);
        check_regs("R6");
        idle(1);
        load_reg("R6", 16'hA000, 5'h05);
    endtask

    task automatic t_soft;
        @(negedge clk);
        wr_en = 1'b1; addr = 16'h8000; data = 8'h01;
        @(negedge clk);
        wr_en = 1'b0; soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        wr_en = 1'b1; addr = 16'hE000; data = 8'h01;
        @(negedge clk);
        wr_en = 1'b0; data = '0;
        e_ctrl = 5'h0C; e_prg = 5'h10;
        check_regs("R8");
        check("R8", "pulse", 32'(commit_pulse), 32'd0);
        load_reg("R8", 16'hE000, 5'h0E);
    endtask

    task automatic t_hard;
        @(negedge clk);
        wr_en = 1'b1; addr = 16'hA000; data = 8'h01;
        @(negedge clk);
        wr_en = 1'b0; hard_rst = 1'b1;
        @(negedge clk);
        hard_rst = 1'b0;
        e_ctrl = 5'h0C; e_chr0 = 5'h00; e_chr1 = 5'h00; e_prg = 5'h10;
        check_regs("R9");
        wr_en = 1'b1; addr = 16'hA000; data = 8'h01;
        @(negedge clk);
        wr_en = 1'b0; data = '0;
        idle(1);
        // bits 0,1,0,0 after the accepted 1 -> 5'b00101
        drive_write(16'hA000, 8'h00); idle(1);
        drive_write(16'hA000, 8'h01); idle(1);
        drive_write(16'hA000, 8'h00); idle(1);
        drive_write(16'hA000, 8'h00);
        e_chr0 = 5'h05;
        check("R9", "guard cleared pulse", 32'(commit_pulse), 32'd1);
        check_regs("R9");
        idle(1);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_load_all();
        t_low_addr();
        t_guard();
        t_bit7();
        t_soft();
        t_hard();
        idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule